// File: doc/BRIEF.md
# Four-Channel Timer Compare Unit with Edge-Triggered Interrupts

This block watches a free-running 16-bit timer value and compares it against four programmable compare registers. Each channel has a compare signal. The signal is active for as long as the timer value equals that channel's register. While it is active, the channel's port latch is copied into the output buffer that drives the pin. The same signal raises the channel's interrupt request flag. Software writes the next output level into the port latch, which acts as a shadow latch. The level then reaches the pin at the next match, so the pin edge does not depend on how long an interrupt takes to be serviced.

Each channel can be put in compare mode or left as a plain port. In compare mode, the interrupt comes from the compare signal. Pin activity cannot set the flag, although the synchronised pin level stays readable. As a plain port, the latch drives the pin directly, and a falling edge on the synchronised pin input sets the flag. Channel 0 has an edge-select input that chooses whether its flag is set when a match begins or when it ends. Channels 1 to 3 always use the start of a match.

Each channel tracks its compare signal with a two-state machine. The states are `CS_IDLE` (no match) and `CS_MATCH` (timer equals register). The transition *match-begin* (`CS_IDLE`→`CS_MATCH`) fires when the count becomes equal. The transition *match-end* (`CS_MATCH`→`CS_IDLE`) fires when the count moves away. These two transitions are the rising and falling compare edges.

Top module: `cmp_irq_unit`

## Requirements
- R1: While the timer value equals a channel's compare register, that channel's compare signal stays active on every clock. Each latch write made during that time appears on the channel's `pin_out` bit one clock later.
- R2: With `cmp_mode[n]`=1, a falling or rising edge on `pin_in[n]` never sets `irq_flag[n]`.
- R3: With `cmp_mode[n]`=1, a compare edge of channel n sets `irq_flag[n]` one clock after the timer value changes.
- R4: The flag responds to transitions, not to levels. A match held for many clocks sets the flag once. If the flag is cleared during that match, it stays clear until the next edge.
- R5: In channels 1 to 3, `irq_flag` is set only on match-begin; match-end never sets it.
- R6: Channel 0 sets its flag on match-begin when `ch0_fall_sel`=0 and on match-end when `ch0_fall_sel`=1.
- R7: In compare mode, a latch write (`wr_tgt`=1, value in `wr_data[0]`) made outside a match leaves `pin_out` unchanged. The stored value moves to `pin_out` one clock after the next match-begin.
- R8: A latch write made while the channel's compare signal is active reaches `pin_out` one clock later.
- R9: `pin_level[n]` equals `pin_in[n]` delayed by two clocks, in either mode.
- R10: A set flag stays set until `irq_clr[n]` is pulsed. When a set and a clear occur in the same clock, the flag ends up set.
- R11: With `cmp_mode[n]`=0, a falling edge of `pin_level[n]` sets `irq_flag[n]` one clock later (three clocks after `pin_in`). A rising edge or a timer match does not set it.
- R12: With `cmp_mode[n]`=0, a latch write appears on `pin_out[n]` one clock later, whatever the timer value.
- R13: After reset, `pin_out`=0, `irq_flag`=0 and `pin_level`=all ones, and the compare registers hold all ones. A compare-register write uses `wr_tgt`=0 and loads all 16 bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_cnt | input | 16 | Current timer value |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_tgt | input | 1 | 0 = compare register, 1 = port latch |
| wr_data | input | 16 | Write data (latch uses bit 0) |
| cmp_mode | input | 4 | Per-channel compare-output enable |
| ch0_fall_sel | input | 1 | Channel 0 flag on match-end when 1 |
| pin_in | input | 4 | Raw pin levels |
| pin_level | output | 4 | Synchronised pin levels |
| pin_out | output | 4 | Output buffers driving the pins |
| irq_flag | output | 4 | Interrupt request flags |
| irq_clr | input | 4 | Per-channel flag clear pulses |

## Verification
The bench uses the default configuration of four channels and a 16-bit compare width. Four channels are few enough to sweep every channel through three compare values, and to try both edge selections on channel 0. For each match it computes the expected flag vector and pin vector arithmetically. Holding the timer value for several clocks models a slow timer clock. This makes long matches, clears during a match, and writes during a match reachable. The same sweep is repeated with compare mode off to cover the plain-port interrupt and output paths.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    // Per-channel compare tracking states
    typedef enum logic {
        CS_IDLE  = 1'b0,
        CS_MATCH = 1'b1
    } cmp_state_e;

    // Write target selector
    typedef enum logic {
        WT_CMPREG = 1'b0,
        WT_LATCH  = 1'b1
    } wr_tgt_e;

endpackage

// File: rtl/cmp_pin_sync.sv
module cmp_pin_sync #(
    parameter int NCH    = 4,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] level,
    output logic [NCH-1:0] fall
);

    localparam int DEPTH = STAGES + 1;

    logic [NCH-1:0] sh_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sh_q[i] <= '1;
            end
        end else begin
            sh_q[0] <= pin_in;
            for (int i = 1; i < DEPTH; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    assign level = sh_q[STAGES-1];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
    import cmp_irq_pkg::*;
#(
    parameter int            CW      = 16,
    parameter logic [CW-1:0] RST_CMP = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tmr_cnt,
    input  logic          reg_we,
    input  logic          latch_we,
    input  logic [CW-1:0] wdata,
    input  logic          cmp_mode,
    input  logic          fall_sel,
    input  logic          pin_fall,
    input  logic          clr,
    output logic          out_q,
    output logic          flag_q
);

    logic [CW-1:0] cmp_q;
    cmp_state_e    st_q, st_d;
    logic          cmp_sig;
    logic          evt_rise, evt_fall, cmp_evt, set_flag;
    logic          shadow_q, shadow_d;

    // Compare register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= RST_CMP;
        end else if (reg_we) begin
            cmp_q <= wdata;
        end
    end

    assign cmp_sig = (tmr_cnt == cmp_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and edge outputs
    always_comb begin
        st_d     = st_q;
        evt_rise = 1'b0;
        evt_fall = 1'b0;
        unique case (st_q)
            CS_IDLE: begin
                if (cmp_sig) begin
                    st_d     = CS_MATCH;
                    evt_rise = 1'b1;
                end
            end
            CS_MATCH: begin
                if (!cmp_sig) begin
                    st_d     = CS_IDLE;
                    evt_fall = 1'b1;
                end
            end
            default: st_d = CS_IDLE;
        endcase
    end

    assign cmp_evt  = fall_sel ? evt_fall : evt_rise;
    assign set_flag = cmp_mode ? cmp_evt : pin_fall;
    assign shadow_d = latch_we ? wdata[0] : shadow_q;

    // Shadow latch, output buffer, request flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
            out_q    <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            shadow_q <= shadow_d;
            if (!cmp_mode || cmp_sig) begin
                out_q <= shadow_d;
            end
            flag_q <= set_flag | (flag_q & ~clr);
        end
    end

    AST_PIN_CUT_IN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && $past(cmp_mode)) |-> (st_q != $past(st_q))) // R2
        else $error("pin path reached flag in compare mode");

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && $past(cmp_mode) && !$past(fall_sel)) |-> (st_q == CS_MATCH)) // R5
        else $error("flag set without match-begin");

    AST_FALL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && $past(cmp_mode) && $past(fall_sel)) |-> (st_q == CS_IDLE)) // R6
        else $error("flag set without match-end");

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode && $past(cmp_mode) && !$past(cmp_sig)) |-> $stable(out_q)) // R7
        else $error("output buffer moved outside match");

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) && !$past(clr)) |-> flag_q) // R10
        else $error("flag dropped without clear");

    AST_PORT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && !$past(cmp_mode)) |-> $past(pin_fall)) // R11
        else $error("port-mode flag without pin fall");

endmodule

// File: rtl/cmp_irq_unit.sv
module cmp_irq_unit
    import cmp_irq_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  tmr_cnt,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic           wr_tgt,
    input  logic [CW-1:0]  wr_data,
    input  logic [NCH-1:0] cmp_mode,
    input  logic           ch0_fall_sel,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_level,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] irq_flag,
    input  logic [NCH-1:0] irq_clr
);

    logic [NCH-1:0] pin_fall;
    logic [NCH-1:0] reg_we, latch_we;

    cmp_pin_sync #(
        .NCH    (NCH),
        .STAGES (2)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (pin_level),
        .fall   (pin_fall)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit, fsel;
        assign hit         = wr_en && (wr_ch == CHW'(g));
        assign reg_we[g]   = hit && (wr_tgt == WT_CMPREG);
        assign latch_we[g] = hit && (wr_tgt == WT_LATCH);

        if (g == 0) begin : g_sel
            assign fsel = ch0_fall_sel;
        end else begin : g_fix
            assign fsel = 1'b0;
        end

        cmp_chan #(
            .CW (CW)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tmr_cnt  (tmr_cnt),
            .reg_we   (reg_we[g]),
            .latch_we (latch_we[g]),
            .wdata    (wr_data),
            .cmp_mode (cmp_mode[g]),
            .fall_sel (fsel),
            .pin_fall (pin_fall[g]),
            .clr      (irq_clr[g]),
            .out_q    (pin_out[g]),
            .flag_q   (irq_flag[g])
        );
    end

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we | latch_we)) // R13
        else $error("write decoded to several channels");

endmodule

// File: tb/cmp_irq_unit_tb_top.sv
`timescale 1ns/100ps
module cmp_irq_unit_tb_top;

    localparam int NCH = 4;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  tmr_cnt = '0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic           wr_tgt = 1'b0;
    logic [CW-1:0]  wr_data = '0;
    logic [NCH-1:0] cmp_mode = '0;
    logic           ch0_fall_sel = 1'b0;
    logic [NCH-1:0] pin_in = '1;
    logic [NCH-1:0] pin_level, pin_out, irq_flag;
    logic [NCH-1:0] irq_clr = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cmp_irq_unit #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_tgt(wr_tgt), .wr_data(wr_data),
        .cmp_mode(cmp_mode), .ch0_fall_sel(ch0_fall_sel), .pin_in(pin_in),
        .pin_level(pin_level), .pin_out(pin_out), .irq_flag(irq_flag),
        .irq_clr(irq_clr)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic tgt, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_tgt = tgt; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic clr_all();
        irq_clr = '1;
        tick(1);
        irq_clr = '0;
    endtask

    function automatic logic [CW-1:0] cval(input int ch, input int k);
        return CW'(16'h0123 * (ch + 1) + k * 16'h1111);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] exp_out;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R13 pin_out reset", 32'(pin_out), 32'h0);
        chk("R13 irq_flag reset", 32'(irq_flag), 32'h0);
        chk("R13 pin_level reset", 32'(pin_level), 32'hF);

        // compare-mode sweep
        cmp_mode = '1;
        exp_out  = '0;
        for (int k = 0; k < 3; k++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                logic b;
                wr(ch, 1'b0, cval(ch, k));
                b = ~exp_out[ch];
                wr(ch, 1'b1, CW'(b));
                tick(1);
                chk("R7 write outside match holds pin", 32'(pin_out), 32'(exp_out));
                tmr_cnt = cval(ch, k);
                tick(1);
                exp_out[ch] = b;
                chk("R7 shadow moves on match-begin", 32'(pin_out), 32'(exp_out));
                chk("R3 R5 flag on match-begin", 32'(irq_flag), 32'(1 << ch));
                for (int j = 0; j < 4; j++) begin
                    b = ~b;
                    wr(ch, 1'b1, CW'(b));
                    exp_out[ch] = b;
                    chk("R1 R8 write during match reaches pin", 32'(pin_out), 32'(exp_out));
                end
                irq_clr[ch] = 1'b1;
                tick(1);
                irq_clr[ch] = 1'b0;
                tick(4);
                chk("R4 level does not re-set flag", 32'(irq_flag), 32'h0);
                tmr_cnt = 16'h0000;
                tick(1);
                chk("R5 R6 match-end does not set flag", 32'(irq_flag), 32'h0);
                wr(ch, 1'b1, CW'(~b));
                tick(1);
                chk("R7 after match pin held", 32'(pin_out), 32'(exp_out));
                wr(ch, 1'b1, CW'(b));
            end
        end

        // channel 0 on match-end
        ch0_fall_sel = 1'b1;
        tmr_cnt = cval(0, 2);
        tick(3);
        chk("R6 no flag on match-begin when fall selected", 32'(irq_flag), 32'h0);
        tmr_cnt = 16'h0000;
        tick(1);
        chk("R6 flag on match-end", 32'(irq_flag), 32'h1);
        clr_all();
        ch0_fall_sel = 1'b0;

        // pin activity in compare mode
        pin_in = '0;
        tick(2);
        chk("R9 pin level in compare mode", 32'(pin_level), 32'h0);
        tick(3);
        chk("R2 pin fall ignored in compare mode", 32'(irq_flag), 32'h0);
        pin_in = '1;
        tick(5);
        chk("R2 pin rise ignored in compare mode", 32'(irq_flag), 32'h0);

        // set beats clear, sticky flag
        tmr_cnt = cval(1, 2);
        irq_clr = 4'b0010;
        tick(1);
        irq_clr = '0;
        chk("R10 set wins over clear", 32'(irq_flag), 32'h2);
        tmr_cnt = 16'h0000;
        tick(6);
        chk("R10 flag sticky", 32'(irq_flag), 32'h2);
        irq_clr = 4'b0010;
        tick(1);
        irq_clr = '0;
        chk("R10 clear drops flag", 32'(irq_flag), 32'h0);

        // port mode sweep
        cmp_mode = '0;
        tick(1);
        for (int ch = 0; ch < NCH; ch++) begin
            tmr_cnt = cval(ch, 2);
            tick(2);
            chk("R11 match ignored in port mode", 32'(irq_flag), 32'h0);
            tmr_cnt = 16'h0000;
            wr(ch, 1'b1, CW'(1));
            chk("R12 latch drives pin in port mode", 32'(pin_out[ch]), 32'h1);
            wr(ch, 1'b1, CW'(0));
            chk("R12 latch drives pin low in port mode", 32'(pin_out[ch]), 32'h0);
            pin_in[ch] = 1'b0;
            tick(2);
            chk("R9 pin level after two clocks", 32'(pin_level), 32'(4'hF & ~(4'b1 << ch)));
            chk("R11 flag not yet set", 32'(irq_flag), 32'h0);
            tick(1);
            chk("R11 pin fall sets flag", 32'(irq_flag), 32'(1 << ch));
            clr_all();
            pin_in[ch] = 1'b1;
            tick(5);
            chk("R11 pin rise does not set flag", 32'(irq_flag), 32'h0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule